// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO

This block is a first-in first-out buffer with independent write and read clocks. Each word is 9 bits wide by default, and the depth is a power of two set by a parameter. A mode input is captured while the master reset is held. That choice sets two things: how the two status outputs read, and how the first word reaches the read side.

In standard mode, the read status is an empty flag and the write status is a full flag. A stored word shows on the data output only after the reader asks for it. In fall-through mode, the read status means "a word is waiting on the output" and the write status means "there is room". The first word written into an empty buffer moves to the output without any read request. Each later word then advances on a read.

A partial reset clears only the pointers and keeps the captured mode. A retransmit input rewinds the read pointer to the first memory location, so the stored data can be read a second time. An active-low output enable replaces the data output with an all-ones idle word. This idle word stands in for high impedance.

Top module: `dual_mode_fifo`

## Requirements
- R1: The timing mode is captured from `fwft_sel` on every read- and write-clock edge while `mrst` is high: 0 selects standard mode and 1 selects fall-through mode. Changes on `fwft_sel` at any other time, including during a partial reset, have no effect.
- R2: After a master or partial reset, standard mode shows `rd_flag`=1 and `wr_flag`=0. Fall-through mode shows `rd_flag`=0 and `wr_flag`=1.
- R3: In standard mode, `dout` changes only as the result of a read, which is `ren_n` low at a rising `rclk` edge while `rd_flag` is 0. A read attempted while `rd_flag`=1 leaves `dout` and the read pointer unchanged.
- R4: In standard mode, a word written into an empty buffer clears `rd_flag` at the third rising `rclk` edge after the write edge.
- R5: In fall-through mode, a word written into an empty buffer appears on `dout`, with `rd_flag` set, at the third rising `rclk` edge after the write edge. `ren_n` stays high throughout.
- R6: In fall-through mode, the output word holds while `ren_n` is high. A read loads the next stored word. A read with nothing stored behind the current word clears `rd_flag`.
- R7: In standard mode, `wr_flag` rises at the write edge that stores the DEPTH-th unread word. Writes while full are dropped, so exactly DEPTH words can be read back.
- R8: Words leave in the order they were written, across pointer wrap-around and repeated fills.
- R9: A partial reset (`prst` high) empties the buffer. The next word written is the next word read.
- R10: `rt_n` low at a rising `rclk` edge sets the read pointer to the first memory location. The words stored from there are then read again in the same order.
- R11: With `oe_n` high, `dout` is all ones (9'h1FF). With `oe_n` low, `dout` shows the current output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, active high, held over edges of both clocks |
| prst | input | 1 | Partial reset, clears pointers only, active high |
| fwft_sel | input | 1 | Mode select captured during master reset (1 = fall-through) |
| wen_n | input | 1 | Write enable, active low |
| din | input | 9 | Write data |
| ren_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rt_n | input | 1 | Retransmit request, active low |
| dout | output | 9 | Read data, idle word when disabled |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |

## Verification
The bench counts read-clock edges after a single write and checks both status flags at each edge. A design with one synchroniser stage too many or too few would move the flag change, or the fall-through word, by one edge. It fills the buffer past its depth twice, so pointer wrap and dropped overflow writes are both exercised. A full flag raised one write late would let a stored word be overwritten, and a pointer that still advanced while full would corrupt the read-back order. The bench also changes the mode input during a partial reset and after a master reset; a design that re-sampled it would flip the meaning of the flags. Finally it rewinds the reader after draining the buffer and expects the same words again, which a retransmit that reset only the flag would not produce.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/fifo_ram.sv
// Simple dual-port storage: one write port, one registered read port.
module fifo_ram #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_sync2.sv
// Two-stage synchroniser for a Gray-coded pointer.
module fifo_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fifo_wctl.sv
// Write-domain control: pointer, full detection, mode copy.
module fifo_wctl
  import fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          mode_sel,
  input  logic          wen_n,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_do,
  output logic          wr_flag
);
  fifo_mode_e  mode;
  logic [AW:0] wbin, wbin_nx, wgray_nx, full_ref;
  logic        full_q;
  logic        rst_any;

  always_comb begin
    rst_any  = mrst | prst;
    wr_do    = !rst_any && !wen_n && !full_q;
    wbin_nx  = wbin + {{AW{1'b0}}, wr_do};
    wgray_nx = wbin_nx ^ (wbin_nx >> 1);
    full_ref = {~rgray_s[AW:AW-1], rgray_s[AW-2:0]};
  end

  always_ff @(posedge wclk) begin
    if (mrst) mode <= mode_sel ? MODE_FWFT : MODE_STD;
  end

  always_ff @(posedge wclk) begin
    if (rst_any) begin
      wbin   <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      full_q <= (wgray_nx == full_ref);
    end
  end

  assign waddr   = wbin[AW-1:0];
  assign wr_flag = (mode == MODE_STD) ? full_q : !full_q;

  // R7: a write attempt while full leaves the pointer where it was
  a_r7_no_overflow: assert property (@(posedge wclk) disable iff (mrst || prst)
    (full_q && !wen_n) |=> $stable(wbin));

  // R9: partial reset returns the write side to its first location, not full
  a_r9_partial_wptr: assert property (@(posedge wclk) disable iff (mrst)
    prst |=> (wbin == '0) && !full_q);
endmodule

// File: rtl/fifo_rctl.sv
// Read-domain control: pointer, empty detection, fall-through output state,
// retransmit rewind, mode copy.
module fifo_rctl
  import fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          mode_sel,
  input  logic          ren_n,
  input  logic          rt_n,
  input  logic [AW:0]   wgray_s,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          rd_do,
  output logic          rd_flag
);
  fifo_mode_e  mode;
  logic [AW:0] rbin, rbin_nx, rgray_nx;
  logic        empty_q, ovalid, ovalid_nx, mem_empty_c, rst_any;

  always_comb begin
    rst_any     = mrst | prst;
    mem_empty_c = (rgray == wgray_s);
    if (mode == MODE_STD)
      rd_do = !rst_any && rt_n && !ren_n && !empty_q;
    else
      rd_do = !rst_any && rt_n && !mem_empty_c && (!ovalid || !ren_n);
    rbin_nx  = rt_n ? (rbin + {{AW{1'b0}}, rd_do}) : '0;
    rgray_nx = rbin_nx ^ (rbin_nx >> 1);
    if (mode == MODE_STD || !rt_n) ovalid_nx = 1'b0;
    else if (rd_do)                ovalid_nx = 1'b1;
    else if (!ren_n)               ovalid_nx = 1'b0;
    else                           ovalid_nx = ovalid;
  end

  always_ff @(posedge rclk) begin
    if (mrst) mode <= mode_sel ? MODE_FWFT : MODE_STD;
  end

  always_ff @(posedge rclk) begin
    if (rst_any) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_q <= 1'b1;
      ovalid  <= 1'b0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rgray_nx;
      empty_q <= (rgray_nx == wgray_s);
      ovalid  <= ovalid_nx;
    end
  end

  assign raddr   = rbin[AW-1:0];
  assign rd_flag = (mode == MODE_STD) ? empty_q : ovalid;

  // R1: the mode copy moves only under master reset
  a_r1_mode_hold: assert property (@(posedge rclk) disable iff (mrst)
    1'b1 |=> $stable(mode));

  // R3: a standard-mode read on an empty buffer leaves the pointer alone
  a_r3_no_underflow: assert property (@(posedge rclk) disable iff (mrst || prst)
    (mode == MODE_STD && empty_q && !ren_n && rt_n) |=> $stable(rbin));

  // R6: a fall-through word stays valid until it is read
  a_r6_hold_word: assert property (@(posedge rclk) disable iff (mrst || prst)
    (mode == MODE_FWFT && ovalid && ren_n && rt_n) |=> ovalid);

  // R10: retransmit lands the read pointer on the first location
  a_r10_rewind: assert property (@(posedge rclk) disable iff (mrst || prst)
    !rt_n |=> (rbin == '0));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int          DW   = 9,
  parameter int          AW   = 4,
  parameter logic [DW-1:0] IDLE = '1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  input  logic          ren_n,
  input  logic          oe_n,
  input  logic          rt_n,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          wr_flag
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wr_do, rd_do;
  logic [DW-1:0] rdata;
  logic          wrst, rrst;

  assign wrst = mrst | prst;
  assign rrst = mrst | prst;

  fifo_wctl #(.AW(AW)) u_wctl (
    .wclk(wclk), .mrst(mrst), .prst(prst), .mode_sel(fwft_sel),
    .wen_n(wen_n), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
    .wr_do(wr_do), .wr_flag(wr_flag)
  );

  fifo_rctl #(.AW(AW)) u_rctl (
    .rclk(rclk), .mrst(mrst), .prst(prst), .mode_sel(fwft_sel),
    .ren_n(ren_n), .rt_n(rt_n), .wgray_s(wgray_s), .rgray(rgray),
    .raddr(raddr), .rd_do(rd_do), .rd_flag(rd_flag)
  );

  fifo_sync2 #(.W(PW)) u_sync_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
  );

  fifo_sync2 #(.W(PW)) u_sync_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s)
  );

  fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_do), .waddr(waddr), .wdata(din),
    .rclk(rclk), .re(rd_do), .raddr(raddr), .rdata(rdata)
  );

  assign dout = oe_n ? IDLE : rdata;
endmodule

// File: tb/sim_dual_mode_fifo.sv
module sim_dual_mode_fifo;
  localparam int DW    = 9;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0;
  logic          wen_n = 1'b1, ren_n = 1'b1, oe_n = 1'b0, rt_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          rd_flag, wr_flag;

  int n_run  = 0;
  int n_fail = 0;

  always #10 wclk = ~wclk;
  initial begin
    #5;
    forever #10 rclk = ~rclk;
  end

  dual_mode_fifo #(.DW(DW), .AW(AW)) u0 (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .wen_n(wen_n), .din(din), .ren_n(ren_n), .oe_n(oe_n), .rt_n(rt_n),
    .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit master, input bit sel);
    @(negedge wclk);
    fwft_sel = sel; wen_n = 1'b1; ren_n = 1'b1; rt_n = 1'b1;
    if (master) mrst = 1'b1; else prst = 1'b1;
    repeat (3) @(negedge wclk);
    mrst = 1'b0; prst = 1'b0;
    repeat (4) @(negedge rclk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk); wen_n = 1'b0; din = d;
    @(negedge wclk); wen_n = 1'b1;
  endtask

  task automatic rd(output logic [DW-1:0] d);
    @(negedge rclk); ren_n = 1'b0;
    @(negedge rclk); ren_n = 1'b1;
    d = dout;
  endtask

  task automatic t_std_basic();
    logic [DW-1:0] prev, got;
    do_reset(1'b1, 1'b0);
    chk("R2 std empty after reset", {8'd0, rd_flag}, 9'd1);
    chk("R2 std not full after reset", {8'd0, wr_flag}, 9'd0);
    prev = dout;
    wr(9'h0A5);
    @(negedge rclk); chk("R4 edge1 still empty", {8'd0, rd_flag}, 9'd1);
    @(negedge rclk); chk("R4 edge2 still empty", {8'd0, rd_flag}, 9'd1);
    @(negedge rclk); chk("R4 edge3 not empty", {8'd0, rd_flag}, 9'd0);
    chk("R3 no data before read", dout, prev);
    rd(got);
    chk("R3 data after read", got, 9'h0A5);
    chk("R3 empty after last read", {8'd0, rd_flag}, 9'd1);
    rd(got);
    chk("R3 read on empty ignored", got, 9'h0A5);
  endtask

  task automatic t_std_fill();
    logic [DW-1:0] got;
    for (int round = 0; round < 2; round++) begin
      @(negedge wclk); wen_n = 1'b0;
      for (int i = 0; i < DEPTH + 2; i++) begin
        din = DW'((round * 37 + i * 11 + 3) & 9'h1FF);
        @(negedge wclk);
        if (i == DEPTH - 2) chk("R7 not full one short", {8'd0, wr_flag}, 9'd0);
        if (i == DEPTH - 1) chk("R7 full at depth", {8'd0, wr_flag}, 9'd1);
      end
      wen_n = 1'b1;
      repeat (4) @(negedge rclk);
      for (int i = 0; i < DEPTH; i++) begin
        rd(got);
        chk("R8 order across wrap", got, DW'((round * 37 + i * 11 + 3) & 9'h1FF));
      end
      chk("R7 overflow writes dropped", {8'd0, rd_flag}, 9'd1);
      repeat (4) @(negedge wclk);
      chk("R7 full clears after drain", {8'd0, wr_flag}, 9'd0);
    end
  endtask

  task automatic t_oe();
    logic [DW-1:0] last;
    last = dout;
    @(negedge rclk); oe_n = 1'b1;
    @(negedge rclk); chk("R11 idle word when disabled", dout, 9'h1FF);
    oe_n = 1'b0;
    @(negedge rclk); chk("R11 word when enabled", dout, last);
  endtask

  task automatic t_fwft();
    logic [DW-1:0] got;
    do_reset(1'b1, 1'b1);
    chk("R2 fwft not ready after reset", {8'd0, rd_flag}, 9'd0);
    chk("R2 fwft input ready after reset", {8'd0, wr_flag}, 9'd1);
    wr(9'h111);
    @(negedge rclk); chk("R5 edge1 not ready", {8'd0, rd_flag}, 9'd0);
    @(negedge rclk); chk("R5 edge2 not ready", {8'd0, rd_flag}, 9'd0);
    @(negedge rclk); chk("R5 edge3 ready", {8'd0, rd_flag}, 9'd1);
    chk("R5 word fell through", dout, 9'h111);
    wr(9'h122); wr(9'h133);
    repeat (5) @(negedge rclk);
    chk("R6 word held without read", dout, 9'h111);
    rd(got); chk("R6 second word", got, 9'h122);
    rd(got); chk("R6 third word", got, 9'h133);
    chk("R6 still ready", {8'd0, rd_flag}, 9'd1);
    rd(got); chk("R6 ready drops when drained", {8'd0, rd_flag}, 9'd0);
  endtask

  task automatic t_partial();
    wr(9'h144); wr(9'h155);
    repeat (5) @(negedge rclk);
    do_reset(1'b0, 1'b0);
    chk("R1 R9 fwft polarity kept, not ready", {8'd0, rd_flag}, 9'd0);
    chk("R1 R9 fwft polarity kept, input ready", {8'd0, wr_flag}, 9'd1);
    wr(9'h166);
    repeat (3) @(negedge rclk);
    chk("R9 ready with new word", {8'd0, rd_flag}, 9'd1);
    chk("R9 old words discarded", dout, 9'h166);
  endtask

  task automatic t_retransmit();
    logic [DW-1:0] got;
    do_reset(1'b1, 1'b0);
    fwft_sel = 1'b1;
    for (int i = 0; i < 4; i++) wr(DW'(9'h020 + i));
    repeat (4) @(negedge rclk);
    chk("R1 std flag kept after select change", {8'd0, rd_flag}, 9'd0);
    for (int i = 0; i < 4; i++) begin
      rd(got); chk("R10 first pass", got, DW'(9'h020 + i));
    end
    chk("R10 empty before rewind", {8'd0, rd_flag}, 9'd1);
    @(negedge rclk); rt_n = 1'b0;
    @(negedge rclk); rt_n = 1'b1;
    chk("R10 data available after rewind", {8'd0, rd_flag}, 9'd0);
    for (int i = 0; i < 4; i++) begin
      rd(got); chk("R10 second pass", got, DW'(9'h020 + i));
    end
    chk("R10 empty after second pass", {8'd0, rd_flag}, 9'd1);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_std_basic();
    t_std_fill();
    t_oe();
    t_fwft();
    t_partial();
    t_retransmit();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule